// File: doc/BRIEF.md
# Four-Sample Block Rate Converter Pair

This block holds two converters that share one phase counter and work on a block of four samples. The gathering converter takes a serial sample stream at the fast rate. On every fourth sample it presents the last four samples side by side as one parallel word. The parallel side therefore updates at a quarter of the fast rate. The scattering converter takes a four-lane parallel word and plays it back one sample per strobe, starting with the lowest lane.

The fast rate is set by a sample strobe `samp_en` that is sampled on the fast clock. When the strobe is low, every register in the block holds its value. A 2-bit phase counter numbers the samples 0 to 3 within each block. The gatherer captures its block on the phase-3 sample. The scatterer loads its block on the phase-0 sample. The scatterer's serial output can be fed through a processing stage back into the parallel input. With the gatherer's parallel output wired straight to the scatterer's parallel input, the pair returns the input stream four samples later.

Top module: `sample_block_converter`

## Requirements
- R1: After reset, `phase` is 0. It advances by one, wrapping from 3 to 0, on each clock edge where `samp_en` is high, and holds on edges where `samp_en` is low.
- R2: The gatherer delays its input through three one-sample registers clocked by `samp_en`. A captured word holds sample 4k+i in lane i, bits [i*W +: W], so sample 4k sits in lane 0 and sample 4k+3 in lane 3.
- R3: `par_out` is loaded only on the sample strobe taken in phase 3, which is also the strobe carrying sample 4k+3. Between loads it holds its value.
- R4: `par_out_vld` is high for exactly one clock, the clock after the phase-3 strobe.
- R5: On the phase-0 strobe with `par_in_vld` high, the scatterer loads all four lanes of `par_in`. It emits lane 0 in the cycle after that strobe, then lanes 1, 2 and 3, one per later strobe.
- R6: On later strobes, zeros are shifted into the tail of the scatterer's chain. A phase-0 strobe with `par_in_vld` low loads a block of four zero samples.
- R7: `ser_out_vld` is high for one clock after each strobe. `ser_out_first` is high together with it only for the lane-0 sample. `ser_out` holds its value between strobes.
- R8: With `par_out` wired to `par_in`, the sample presented on strobe n appears on `ser_out` after strobe n+4. The first four outputs after reset are zero.
- R9: While reset is active, `par_out`, `ser_out` and all three strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Sample strobe, one serial sample per high cycle |
| ser_in | input | W | Serial input sample |
| par_out | output | 4*W | Gathered block, lane i holds sample 4k+i |
| par_out_vld | output | 1 | One-clock block-valid strobe of the gatherer |
| par_in | input | 4*W | Block to scatter, lane 0 emitted first |
| par_in_vld | input | 1 | Block-valid qualifier, sampled on the phase-0 strobe |
| ser_out | output | W | Serial output sample |
| ser_out_vld | output | 1 | One clock after each strobe |
| ser_out_first | output | 1 | Marks the lane-0 sample of each emitted block |

## Verification
The pair is first run with a strobe on every clock and the parallel valid wired back. This tests lane order and the four-sample loop latency with no idle time in between. A second run spaces the strobes irregularly and holds the parallel valid high. It separates strobe-driven state changes from clock-driven ones: a design that advances phase or shifts without a strobe shows up as misaligned blocks or as a moving output between strobes. A third run keeps the parallel valid low, so every emitted sample must be zero. This shows whether loads are qualified and whether zeros are filled in.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    localparam int BLK  = 4;
    localparam int PH_W = $clog2(BLK);
    localparam int NDLY = BLK - 1;
endpackage

// File: rtl/sbc_phase.sv
module sbc_phase
    import sbc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            samp_en,
    output logic [PH_W-1:0] phase
);
    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (samp_en) st_d.ph = st_q.ph + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.ph;

    // R1: a strobe moves the phase on by one, no strobe keeps it
    a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        samp_en |=> (phase == PH_W'($past(phase) + PH_W'(1))));
    a_r1_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> $stable(phase));
endmodule

// File: rtl/sbc_ser2par.sv
module sbc_ser2par
    import sbc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic [PH_W-1:0]  phase,
    input  logic [W-1:0]     ser_in,
    output logic [BLK*W-1:0] par_out,
    output logic             par_vld
);
    localparam logic [PH_W-1:0] CAP_PH = PH_W'(BLK - 1);

    typedef struct packed {
        logic [NDLY-1:0][W-1:0] dly;
        logic [BLK*W-1:0]       par;
        logic                   vld;
    } g_st_t;

    g_st_t st_d, st_q;
    logic [BLK-1:0][W-1:0] tap;

    // tap[BLK-1] is the live sample, deeper taps are older samples
    assign tap[BLK-1] = ser_in;
    for (genvar i = 0; i < NDLY; i++) begin : g_tap
        assign tap[i] = st_q.dly[NDLY-1-i];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (samp_en) begin
            st_d.dly[0] = ser_in;
            for (int i = 1; i < NDLY; i++) st_d.dly[i] = st_q.dly[i-1];
            if (phase == CAP_PH) begin
                for (int i = 0; i < BLK; i++) st_d.par[i*W +: W] = tap[i];
                st_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign par_out = st_q.par;
    assign par_vld = st_q.vld;

    // R4: the valid strobe never lasts two clocks
    a_r4_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        par_vld |=> !par_vld);
    // R2: the top lane carries the sample that arrived with the capture
    a_r2_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && phase == CAP_PH) |=> (par_out[(BLK-1)*W +: W] == $past(ser_in)));
    // R3: the word is frozen when no capture took place
    a_r3_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_en && phase == CAP_PH) |=> $stable(par_out));
endmodule

// File: rtl/sbc_par2ser.sv
module sbc_par2ser
    import sbc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic [PH_W-1:0]  phase,
    input  logic [BLK*W-1:0] par_in,
    input  logic             par_in_vld,
    output logic [W-1:0]     ser_out,
    output logic             ser_vld,
    output logic             ser_first
);
    localparam logic [PH_W-1:0] LD_PH = '0;

    typedef struct packed {
        logic [BLK-1:0][W-1:0] sh;
        logic                  vld;
        logic                  first;
    } s_st_t;

    s_st_t st_d, st_q;
    logic  load;

    assign load = samp_en && (phase == LD_PH);

    always_comb begin
        st_d       = st_q;
        st_d.vld   = samp_en;
        st_d.first = load;
        if (load) begin
            for (int i = 0; i < BLK; i++)
                st_d.sh[i] = par_in_vld ? par_in[i*W +: W] : '0;
        end else if (samp_en) begin
            for (int i = 0; i < BLK-1; i++) st_d.sh[i] = st_q.sh[i+1];
            st_d.sh[BLK-1] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_out   = st_q.sh[0];
    assign ser_vld   = st_q.vld;
    assign ser_first = st_q.first;

    // R6: a shift step feeds zero into the tail
    a_r6_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && !load) |=> (st_q.sh[BLK-1] == '0));
    // R5: lane 0 of a qualified block is the first sample out
    a_r5_lane0_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load && par_in_vld) |=> (ser_out == $past(par_in[W-1:0])));
    // R7: output frozen between strobes, first flag only on a valid sample
    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> $stable(ser_out));
    a_r7_first_in_vld: assert property (@(posedge clk) disable iff (!rst_n)
        ser_first |-> ser_vld);
endmodule

// File: rtl/sample_block_converter.sv
module sample_block_converter
    import sbc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic [W-1:0]     ser_in,
    output logic [BLK*W-1:0] par_out,
    output logic             par_out_vld,
    input  logic [BLK*W-1:0] par_in,
    input  logic             par_in_vld,
    output logic [W-1:0]     ser_out,
    output logic             ser_out_vld,
    output logic             ser_out_first
);
    logic [PH_W-1:0] phase;

    sbc_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .samp_en (samp_en),
        .phase   (phase)
    );

    sbc_ser2par #(.W(W)) u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .samp_en (samp_en),
        .phase   (phase),
        .ser_in  (ser_in),
        .par_out (par_out),
        .par_vld (par_out_vld)
    );

    sbc_par2ser #(.W(W)) u_scatter (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_en    (samp_en),
        .phase      (phase),
        .par_in     (par_in),
        .par_in_vld (par_in_vld),
        .ser_out    (ser_out),
        .ser_vld    (ser_out_vld),
        .ser_first  (ser_out_first)
    );

    // R7: the output valid follows every strobe by one clock
    a_r7_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        samp_en |=> ser_out_vld);
endmodule

// File: tb/sample_block_converter_bench.sv
`timescale 1ns/1ps
module sample_block_converter_bench;
    localparam int W = 16;
    localparam int B = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           samp_en = 1'b0;
    logic [W-1:0]   ser_in = '0;
    logic [B*W-1:0] par_out;
    logic           par_out_vld;
    logic           par_in_vld;
    logic [W-1:0]   ser_out;
    logic           ser_out_vld;
    logic           ser_out_first;

    int mode = 0;          // 0 dense loop, 1 sparse held valid, 2 valid low
    int n_run = 0;
    int n_fail = 0;

    logic [W-1:0]   exp_ser[$];
    logic [B*W-1:0] exp_blk[$];

    always #2 clk = ~clk;  // 250 MHz

    assign par_in_vld = (mode == 0) ? par_out_vld : (mode == 1);

    sample_block_converter #(.W(W)) u_sample_block_converter (
        .clk           (clk),
        .rst_n         (rst_n),
        .samp_en       (samp_en),
        .ser_in        (ser_in),
        .par_out       (par_out),
        .par_out_vld   (par_out_vld),
        .par_in        (par_out),
        .par_in_vld    (par_in_vld),
        .ser_out       (ser_out),
        .ser_out_vld   (ser_out_vld),
        .ser_out_first (ser_out_first)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, expv, $time);
        end
    endtask

    // monitor: pops the scoreboard as results appear
    int             out_idx;
    logic [W-1:0]   last_ser;
    logic [B*W-1:0] last_par;
    logic           prev_pvld;
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            out_idx = 0; last_ser = '0; last_par = '0; prev_pvld = 1'b0;
        end else begin
            if (ser_out_vld) begin
                if (exp_ser.size() == 0) chk(1'b0, "R8 unexpected sample", 64'(ser_out), 0);
                else begin
                    logic [W-1:0] e;
                    e = exp_ser.pop_front();
                    chk(ser_out == e, (mode == 2) ? "R6 zero block" : "R5,R8 serial order", 64'(ser_out), 64'(e));
                end
                chk(ser_out_first == (out_idx % B == 0), "R7 first flag", 64'(ser_out_first), 64'(out_idx % B == 0));
                out_idx++;
            end else begin
                chk(ser_out == last_ser, "R7 hold between strobes", 64'(ser_out), 64'(last_ser));
            end
            if (par_out_vld) begin
                chk(!prev_pvld, "R4 single pulse", 64'(prev_pvld), 0);
                if (exp_blk.size() == 0) chk(1'b0, "R3 unexpected block", par_out, 0);
                else begin
                    logic [B*W-1:0] eb;
                    eb = exp_blk.pop_front();
                    chk(par_out == eb, "R1,R2 block lanes", par_out, eb);
                end
            end else begin
                chk(par_out == last_par, "R3 word held", par_out, last_par);
            end
            last_ser  = ser_out;
            last_par  = par_out;
            prev_pvld = par_out_vld;
        end
    end

    task automatic run_test(input int m, input int nsamp);
        logic [B*W-1:0] blk;
        blk = '0;
        @(negedge clk);
        rst_n = 1'b0; samp_en = 1'b0; mode = m;
        exp_ser.delete(); exp_blk.delete();
        @(negedge clk);
        // R9: reset state
        chk(par_out == '0 && ser_out == '0, "R9 reset data", {ser_out, par_out[47:0]}, 0);
        chk(!par_out_vld && !ser_out_vld && !ser_out_first, "R9 reset strobes",
            {61'd0, par_out_vld, ser_out_vld, ser_out_first}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < B; k++) exp_ser.push_back('0);  // R8 leading zeros
        for (int n = 0; n < nsamp; n++) begin
            logic [W-1:0] v;
            if (m != 0) begin
                for (int g = 0; g < (n * 7) % 4; g++) begin
                    samp_en = 1'b0;
                    @(negedge clk);
                end
            end
            v = W'(n * 37 + m * 1009 + 5);
            ser_in  = v;
            samp_en = 1'b1;
            exp_ser.push_back((m == 2) ? '0 : v);
            blk[(n % B)*W +: W] = v;
            if (n % B == B-1) exp_blk.push_back(blk);
            @(negedge clk);
        end
        samp_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(exp_blk.size() == 0, "R3 all blocks seen", 64'(exp_blk.size()), 0);
        chk(exp_ser.size() == B, "R8 latency four", 64'(exp_ser.size()), 64'(B));
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        run_test(0, 200);
        run_test(1, 200);
        run_test(2, 120);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule